// File: doc/BRIEF.md
# Asynchronous PSRAM Bus Controller

This block lets a clocked host read and write a 256K x 16 asynchronous pseudo-static RAM. The host presents a request with an 18-bit word address, 16-bit write data, a two-bit byte mask and a read/write flag. It holds the request until the controller answers with a one-cycle acknowledge. Read data comes back on a registered output with its own one-cycle valid strobe.

On the memory side the controller drives the address bus, an active-low and an active-high chip select, a read strobe, a write strobe and two active-low byte-lane enables. It also drives the data bus through a per-lane output enable. Every phase of an access is timed by one down-counter. The counts are derived at elaboration from a speed-grade parameter (55, 60 or 70 ns parts) and the clock period in picoseconds, using a ceiling division. Reads are chip-select controlled: the address settles one cycle before the selects go active. Writes end on the write strobe, while the selects, lane enables and data stay put for at least one more cycle. After every read the bus is kept quiet for the output-disable float time before anything drives it again.

Top module: `psramBridge`

## Requirements
- R1: Out of reset and whenever no access is in progress, memSelN=1, memSelP=0, memRdN=1, memWrN=1, memHiLaneN=1, memLoLaneN=1, memDqOe=00, reqAck=0 and rdValid=0.
- R2: A read accepted at clock edge a shows its address from cycle a with all strobes inactive. For the next ACC cycles it holds memSelN=0, memSelP=1, memRdN=0 and memWrN=1. During those cycles memLoLaneN is low iff mask bit 0 is set and memHiLaneN is low iff mask bit 1 is set, and memDqOe=00.
- R3: In the cycle after the last read-access cycle, rdValid and reqAck are both high for one cycle. rdData then carries the bus byte for every lane whose mask bit is set and zero in every other lane; bits 7:0 form lane 0 and bits 15:8 form lane 1.
- R4: After a read, all strobes stay inactive and the data bus stays undriven for TURN cycles after the acknowledge cycle begins. The next access starts no earlier than the edge after that.
- R5: A write accepted at edge a selects the chip and lanes and drives data in cycle a with memWrN=1. It then holds memWrN=0 for PULSE cycles and memWrN=1 for HOLD cycles, and acknowledges in the following cycle.
- R6: During a write, memDqOe equals the byte mask and memDqOut equals the write data. The bus is never driven while memRdN is low.
- R7: memWrN rises while both selects and the lane enables are still active and with the driven data unchanged.
- R8: reqAck is a single-cycle pulse, one per accepted request. A request present in the acknowledge cycle is not accepted at the edge that ends that cycle.
- R9: A request with byte mask 00 is acknowledged in the cycle after acceptance. It causes no strobe, address change, bus drive or rdValid, and the memory contents are unchanged.
- R10: ACC = ceil(access time / period) with access times 55/60/70 ns; PULSE = ceil(write-strobe time / period) with 45/45/60 ns; HOLD = max(1, ceil(cycle time / period) - 1 - PULSE); TURN = ceil(25 ns / period). These hold for speed grades 0/1/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; held until reqAck |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | 16 | Write data |
| reqByteEn | input | 2 | Byte mask, bit 0 = lane 0, bit 1 = lane 1 |
| reqAck | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Read data, unselected lanes zero |
| rdValid | output | 1 | One-cycle read data strobe |
| memAddr | output | ADDR_W | Memory address bus |
| memSelN | output | 1 | Active-low chip select |
| memSelP | output | 1 | Active-high chip select |
| memRdN | output | 1 | Active-low output enable of the memory |
| memWrN | output | 1 | Active-low write strobe |
| memHiLaneN | output | 1 | Active-low enable of data bits 15:8 |
| memLoLaneN | output | 1 | Active-low enable of data bits 7:0 |
| memDqOut | output | 16 | Data driven toward the memory |
| memDqOe | output | 2 | Per-lane drive enable for memDqOut |
| memDqIn | input | 16 | Data received from the memory |

## Verification
Accesses run with full, low-only, upper-only and empty masks, so that lane gating of strobes, bus drive and captured data can each be told apart. Lane-restricted writes are read back with different masks to show that untouched bytes survive. Requests come back to back and are presented in the acknowledge cycle, which separates a correct acceptance rule and turnaround from a controller that starts early or accepts twice. A pseudo-random tail mixes reads and writes over a small address window so that reads hit earlier writes. Every pin is compared each cycle against a schedule built from the nanosecond table.

// File: rtl/psramPkg.sv
`timescale 1ns/1ps
package psramPkg;

  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = LANE_W * LANES;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD,
    ST_TURN
  } seqState_e;

  // strobes from the sequencer to the pin registers, decoded from next state
  typedef struct packed {
    logic latch;    // take a new request into the address/data registers
    logic selOn;    // chip selects and masked lane enables active
    logic rdOn;     // memory output enable active
    logic wrOn;     // write strobe active
    logic driveOn;  // drive the masked lanes of the data bus
    logic capture;  // sample the data bus into rdData
  } busStrobe_t;

  function automatic int unsigned nsToCyc(input int unsigned ns, input int unsigned periodPs);
    return (ns * 1000 + periodPs - 1) / periodPs;
  endfunction

  function automatic int unsigned gradeAccessNs(input int unsigned grade);
    case (grade)
      0:       return 55;
      1:       return 60;
      default: return 70;
    endcase
  endfunction

  // minimum cycle time equals the access time in every grade
  function automatic int unsigned gradeCycleNs(input int unsigned grade);
    return gradeAccessNs(grade);
  endfunction

  // longest of address-to-write-end and select-to-write-end
  function automatic int unsigned gradeWrStrobeNs(input int unsigned grade);
    case (grade)
      0, 1:    return 45;
      default: return 60;
    endcase
  endfunction

  function automatic int unsigned gradeFloatNs(input int unsigned grade);
    return (grade > 2) ? 25 : 25;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psramSeq.sv
`timescale 1ns/1ps
module psramSeq
  import psramPkg::*;
#(
  parameter int unsigned SETUP_CYC    = 1,
  parameter int unsigned RD_ACC_CYC   = 11,
  parameter int unsigned WR_PULSE_CYC = 9,
  parameter int unsigned WR_HOLD_CYC  = 1,
  parameter int unsigned TURN_CYC     = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqByteEn,
  output logic       reqAck,
  output busStrobe_t strobe
);

  localparam int unsigned MAX_CYC = maxOf(maxOf(SETUP_CYC, RD_ACC_CYC),
                                          maxOf(maxOf(WR_PULSE_CYC, WR_HOLD_CYC), TURN_CYC));
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  seqState_e        stateQ, stateNext;
  logic [CNT_W-1:0] cntQ, cntNext;
  logic             opWriteQ, opWriteNext;
  logic             ackQ, ackNext;
  logic             latchNext, captureNext;

  always_comb begin
    stateNext   = stateQ;
    cntNext     = cntQ;
    opWriteNext = opWriteQ;
    ackNext     = 1'b0;
    latchNext   = 1'b0;
    captureNext = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid && !ackQ) begin
          if (reqByteEn == 2'b00) begin
            ackNext = 1'b1;
          end else begin
            latchNext   = 1'b1;
            opWriteNext = reqWrite;
            stateNext   = ST_SETUP;
            cntNext     = CNT_W'(SETUP_CYC - 1);
          end
        end
      end
      ST_SETUP: begin
        if (cntQ == '0) begin
          stateNext = ST_ACCESS;
          cntNext   = opWriteQ ? CNT_W'(WR_PULSE_CYC - 1) : CNT_W'(RD_ACC_CYC - 1);
        end else begin
          cntNext = cntQ - CNT_W'(1);
        end
      end
      ST_ACCESS: begin
        if (cntQ == '0) begin
          if (opWriteQ) begin
            stateNext = ST_HOLD;
            cntNext   = CNT_W'(WR_HOLD_CYC - 1);
          end else begin
            stateNext   = ST_TURN;
            cntNext     = CNT_W'(TURN_CYC - 1);
            captureNext = 1'b1;
            ackNext     = 1'b1;
          end
        end else begin
          cntNext = cntQ - CNT_W'(1);
        end
      end
      ST_HOLD: begin
        if (cntQ == '0) begin
          stateNext = ST_IDLE;
          ackNext   = 1'b1;
        end else begin
          cntNext = cntQ - CNT_W'(1);
        end
      end
      ST_TURN: begin
        if (cntQ == '0) begin
          stateNext = ST_IDLE;
        end else begin
          cntNext = cntQ - CNT_W'(1);
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // pins are registered from these, so they follow the state without lag
  always_comb begin
    strobe.latch   = latchNext;
    strobe.capture = captureNext;
    strobe.selOn   = (stateNext == ST_ACCESS) || (stateNext == ST_HOLD) ||
                     ((stateNext == ST_SETUP) && opWriteNext);
    strobe.rdOn    = (stateNext == ST_ACCESS) && !opWriteNext;
    strobe.wrOn    = (stateNext == ST_ACCESS) && opWriteNext;
    strobe.driveOn = opWriteNext && ((stateNext == ST_SETUP) || (stateNext == ST_ACCESS) ||
                                     (stateNext == ST_HOLD));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      cntQ     <= '0;
      opWriteQ <= 1'b0;
      ackQ     <= 1'b0;
    end else begin
      stateQ   <= stateNext;
      cntQ     <= cntNext;
      opWriteQ <= opWriteNext;
      ackQ     <= ackNext;
    end
  end

  assign reqAck = ackQ;

  // R8: acknowledge never lasts two cycles
  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |=> !ackQ);

  // R9: an empty-mask request is answered next cycle without leaving idle
  assert_empty_mask_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && reqValid && !ackQ && reqByteEn == 2'b00)
      |=> (stateQ == ST_IDLE && ackQ));

endmodule

// File: rtl/psramDatapath.sv
`timescale 1ns/1ps
module psramDatapath
  import psramPkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned TURN_CYC = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [LANES-1:0]    reqByteEn,
  input  logic [DATA_W-1:0]   memDqIn,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memSelN,
  output logic                memSelP,
  output logic                memRdN,
  output logic                memWrN,
  output logic                memHiLaneN,
  output logic                memLoLaneN,
  output logic [DATA_W-1:0]   memDqOut,
  output logic [LANES-1:0]    memDqOe
);

  localparam int unsigned QUIET_W = $clog2(TURN_CYC + 1);

  logic [LANES-1:0] maskQ, maskNext;
  logic [LANES-1:0] laneEnN;

  assign maskNext = strobe.latch ? reqByteEn : maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ    <= '0;
      memAddr  <= '0;
      memDqOut <= '0;
      memSelN  <= 1'b1;
      memSelP  <= 1'b0;
      memRdN   <= 1'b1;
      memWrN   <= 1'b1;
      rdValid  <= 1'b0;
    end else begin
      maskQ   <= maskNext;
      if (strobe.latch) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWdata;
      end
      memSelN <= !strobe.selOn;
      memSelP <= strobe.selOn;
      memRdN  <= !strobe.rdOn;
      memWrN  <= !strobe.wrOn;
      rdValid <= strobe.capture;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic              enNQ;
    logic              oeQ;
    logic [LANE_W-1:0] rdQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enNQ <= 1'b1;
        oeQ  <= 1'b0;
        rdQ  <= '0;
      end else begin
        enNQ <= !(strobe.selOn && maskNext[g]);
        oeQ  <= strobe.driveOn && maskNext[g];
        if (strobe.capture) begin
          rdQ <= maskQ[g] ? memDqIn[g*LANE_W +: LANE_W] : '0;
        end
      end
    end
    assign laneEnN[g]                 = enNQ;
    assign memDqOe[g]                 = oeQ;
    assign rdData[g*LANE_W +: LANE_W] = rdQ;
  end

  assign memLoLaneN = laneEnN[0];
  assign memHiLaneN = laneEnN[1];

  // cycles since the memory output enable was last active, for the float check
  logic [QUIET_W-1:0] quietCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= QUIET_W'(TURN_CYC);
    end else if (!memRdN) begin
      quietCnt <= '0;
    end else if (quietCnt != QUIET_W'(TURN_CYC)) begin
      quietCnt <= quietCnt + QUIET_W'(1);
    end
  end

  // R6: no drive while the memory may be driving
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe != '0) |-> memRdN);

  // R6: a driven lane is always an enabled lane
  assert_drive_in_lane_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe & laneEnN) == '0);

  // R2: output enable and write strobe never overlap
  assert_rd_wr_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(!memRdN && !memWrN));

  // R7: the write strobe is the edge that ends a write
  assert_write_ends_on_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrN) |-> (!memSelN && memSelP && (memDqOe != '0) &&
                       $stable(memDqOut) && $stable(memDqOe) && $stable(laneEnN)));

  // R4: bus stays undriven for the float time after a read
  assert_turnaround_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe != '0) |-> (quietCnt >= QUIET_W'(TURN_CYC)));

endmodule

// File: rtl/psramBridge.sv
`timescale 1ns/1ps
module psramBridge
  import psramPkg::*;
#(
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned SPEED_GRADE   = 0,
  parameter int unsigned CLK_PERIOD_PS = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqByteEn,
  output logic              reqAck,
  output logic [15:0]       rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSelP,
  output logic              memRdN,
  output logic              memWrN,
  output logic              memHiLaneN,
  output logic              memLoLaneN,
  output logic [15:0]       memDqOut,
  output logic [1:0]        memDqOe,
  input  logic [15:0]       memDqIn
);

  localparam int unsigned SETUP_CYC    = 1;
  localparam int unsigned RD_ACC_CYC   = nsToCyc(gradeAccessNs(SPEED_GRADE), CLK_PERIOD_PS);
  localparam int unsigned WR_PULSE_CYC = nsToCyc(gradeWrStrobeNs(SPEED_GRADE), CLK_PERIOD_PS);
  localparam int unsigned WC_CYC       = nsToCyc(gradeCycleNs(SPEED_GRADE), CLK_PERIOD_PS);
  localparam int unsigned WR_HOLD_CYC  = (WC_CYC > SETUP_CYC + WR_PULSE_CYC)
                                         ? WC_CYC - SETUP_CYC - WR_PULSE_CYC : 1;
  localparam int unsigned TURN_CYC     = nsToCyc(gradeFloatNs(SPEED_GRADE), CLK_PERIOD_PS);

  busStrobe_t strobe;

  psramSeq #(
    .SETUP_CYC   (SETUP_CYC),
    .RD_ACC_CYC  (RD_ACC_CYC),
    .WR_PULSE_CYC(WR_PULSE_CYC),
    .WR_HOLD_CYC (WR_HOLD_CYC),
    .TURN_CYC    (TURN_CYC)
  ) uSeq (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqByteEn(reqByteEn),
    .reqAck   (reqAck),
    .strobe   (strobe)
  );

  psramDatapath #(
    .ADDR_W  (ADDR_W),
    .TURN_CYC(TURN_CYC)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqByteEn (reqByteEn),
    .memDqIn   (memDqIn),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .memAddr   (memAddr),
    .memSelN   (memSelN),
    .memSelP   (memSelP),
    .memRdN    (memRdN),
    .memWrN    (memWrN),
    .memHiLaneN(memHiLaneN),
    .memLoLaneN(memLoLaneN),
    .memDqOut  (memDqOut),
    .memDqOe   (memDqOe)
  );

endmodule

// File: tb/tb_psramBridge.sv
`timescale 1ns/1ps
module tb_psramBridge;

  localparam int GRADE    = 0;
  localparam int PERIOD   = 5;   // ns, 200 MHz
  localparam int ACC_NS   = (GRADE == 0) ? 55 : (GRADE == 1) ? 60 : 70;
  localparam int PULSE_NS = (GRADE == 2) ? 60 : 45;
  localparam int ACC      = (ACC_NS + PERIOD - 1) / PERIOD;
  localparam int PULSE    = (PULSE_NS + PERIOD - 1) / PERIOD;
  localparam int WC       = (ACC_NS + PERIOD - 1) / PERIOD;
  localparam int HOLD     = (WC - 1 - PULSE > 1) ? WC - 1 - PULSE : 1;
  localparam int TURN     = (25 + PERIOD - 1) / PERIOD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqByteEn = '0;
  logic        reqAck, rdValid;
  logic [15:0] rdData;
  logic [17:0] memAddr;
  logic        memSelN, memSelP, memRdN, memWrN, memHiLaneN, memLoLaneN;
  logic [15:0] memDqOut;
  logic [1:0]  memDqOe;
  logic [15:0] memDqIn = 16'h5A5A;

  always #2.5 clk = ~clk;

  psramBridge #(.ADDR_W(18), .SPEED_GRADE(GRADE), .CLK_PERIOD_PS(PERIOD * 1000)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqByteEn(reqByteEn), .reqAck(reqAck), .rdData(rdData),
    .rdValid(rdValid), .memAddr(memAddr), .memSelN(memSelN), .memSelP(memSelP),
    .memRdN(memRdN), .memWrN(memWrN), .memHiLaneN(memHiLaneN), .memLoLaneN(memLoLaneN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn));

  typedef struct {
    logic [5:0]  ctrl;    // selN selP rdN wrN hiN loN
    logic [1:0]  oe;
    logic [15:0] dq;
    logic        ack;
    logic        rv;
    logic [15:0] rd;
    bit          addrSet;
    logic [17:0] addr;
    string       tag;
  } pinExp_t;

  pinExp_t     sched[int];
  logic [15:0] shadow[int];
  logic [15:0] memArr[int];
  int cyc = 0, freeEdge = 0, checks = 0, errors = 0;
  logic [17:0] expAddr = '0;
  logic        wrPrev = 1'b1;
  bit          done = 1'b0;

  always @(posedge clk) cyc++;

  function automatic pinExp_t idleExp(input string tag);
    pinExp_t e;
    e.ctrl = 6'b101111; e.oe = 2'b00; e.dq = '0; e.ack = 1'b0; e.rv = 1'b0;
    e.rd = '0; e.addrSet = 1'b0; e.addr = '0; e.tag = tag;
    return e;
  endfunction

  function automatic logic [15:0] laneMask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  // behavioural memory: answers reads, stores a write when the write strobe rises
  always @(negedge clk) begin
    int a;
    logic [15:0] cur, w;
    a = int'(memAddr);
    cur = memArr.exists(a) ? memArr[a] : 16'h0000;
    if (!memSelN && memSelP && !memRdN && memWrN) begin
      memDqIn[7:0]  = !memLoLaneN ? cur[7:0]  : 8'hA5;
      memDqIn[15:8] = !memHiLaneN ? cur[15:8] : 8'hA5;
    end else begin
      memDqIn = 16'h5A5A;
    end
    if (!wrPrev && memWrN && !memSelN && memSelP) begin
      w = cur;
      if (!memLoLaneN) w[7:0]  = memDqOe[0] ? memDqOut[7:0]  : 8'hEE;
      if (!memHiLaneN) w[15:8] = memDqOe[1] ? memDqOut[15:8] : 8'hEE;
      memArr[a] = w;
    end
    wrPrev = memWrN;
  end

  // reference comparison every cycle
  always @(negedge clk) begin
    pinExp_t e;
    e = sched.exists(cyc) ? sched[cyc] : idleExp("R1");
    if (e.addrSet) expAddr = e.addr;
    check({memSelN, memSelP, memRdN, memWrN, memHiLaneN, memLoLaneN} == e.ctrl, e.tag,
          "strobes", 32'({memSelN, memSelP, memRdN, memWrN, memHiLaneN, memLoLaneN}),
          32'(e.ctrl));
    check(memDqOe == e.oe, e.tag, "bus drive", 32'(memDqOe), 32'(e.oe));
    if (e.oe != 2'b00)
      check((memDqOut & laneMask(e.oe)) == (e.dq & laneMask(e.oe)), "R6", "write data",
            32'(memDqOut), 32'(e.dq));
    check(memAddr == expAddr, e.tag, "address", 32'(memAddr), 32'(expAddr));
    check({reqAck, rdValid} == {e.ack, e.rv}, e.tag, "ack/valid",
          32'({reqAck, rdValid}), 32'({e.ack, e.rv}));
    if (e.rv) check(rdData == e.rd, "R3", "read data", 32'(rdData), 32'(e.rd));
  end

  // issue one request at the current negedge and wait for its acknowledge cycle
  task automatic runTxn(input bit wr, input logic [17:0] addr, input logic [15:0] data,
                        input logic [1:0] mask);
    int k, a, ackC;
    pinExp_t e;
    logic [15:0] old, exp;
    k = cyc;
    a = (k + 1 > freeEdge) ? k + 1 : freeEdge;
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = data; reqByteEn = mask;
    old = shadow.exists(int'(addr)) ? shadow[int'(addr)] : 16'h0000;
    if (mask == 2'b00) begin
      ackC = a;
      e = idleExp("R9"); e.ack = 1'b1; sched[ackC] = e;
      freeEdge = ackC + 2;
    end else if (wr) begin
      e = idleExp("R5");
      e.ctrl = {1'b0, 1'b1, 1'b1, 1'b1, !mask[1], !mask[0]};
      e.oe = mask; e.dq = data; e.addrSet = 1'b1; e.addr = addr;
      sched[a] = e;
      e.addrSet = 1'b0; e.ctrl[2] = 1'b0; e.tag = "R5/R10";
      for (int i = 1; i <= PULSE; i++) sched[a + i] = e;
      e.ctrl[2] = 1'b1; e.tag = "R7";
      for (int i = 1; i <= HOLD; i++) sched[a + PULSE + i] = e;
      ackC = a + PULSE + HOLD + 1;
      e = idleExp("R8"); e.ack = 1'b1; sched[ackC] = e;
      shadow[int'(addr)] = (old & ~laneMask(mask)) | (data & laneMask(mask));
      freeEdge = ackC + 2;
    end else begin
      e = idleExp("R2"); e.addrSet = 1'b1; e.addr = addr;
      sched[a] = e;
      e.addrSet = 1'b0; e.tag = "R2/R10";
      e.ctrl = {1'b0, 1'b1, 1'b0, 1'b1, !mask[1], !mask[0]};
      for (int i = 1; i <= ACC; i++) sched[a + i] = e;
      ackC = a + ACC + 1;
      exp = old & laneMask(mask);
      e = idleExp("R3"); e.ack = 1'b1; e.rv = 1'b1; e.rd = exp; sched[ackC] = e;
      for (int i = 1; i < TURN; i++) sched[ackC + i] = idleExp("R4");
      freeEdge = ackC + TURN + 1;
    end
    while (cyc != ackC) @(negedge clk);
    reqValid = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      errors++;
      $display("FAIL R8 watchdog cycle %0d actual hung expected done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (4) @(negedge clk);
    rstN = 1'b1;                          // R1 checked every idle cycle
    repeat (3) @(negedge clk);
    runTxn(1'b1, 18'h00010, 16'h1234, 2'b11);   // R5 R6 R7
    runTxn(1'b0, 18'h00010, 16'h0000, 2'b11);   // R2 R3, presented in ack cycle: R8
    runTxn(1'b1, 18'h00010, 16'hAB77, 2'b01);   // R4 after read, lane 0 only: R6
    runTxn(1'b1, 18'h3FFFF, 16'hCD99, 2'b10);   // lane 1 only: R6
    runTxn(1'b0, 18'h00010, 16'h0000, 2'b01);   // expect 0077: R3
    runTxn(1'b0, 18'h3FFFF, 16'h0000, 2'b10);   // expect CD00, read after read: R4
    runTxn(1'b1, 18'h00010, 16'hFFFF, 2'b00);   // R9 empty write
    runTxn(1'b0, 18'h00010, 16'h0000, 2'b00);   // R9 empty read
    runTxn(1'b0, 18'h00010, 16'h0000, 2'b11);   // R9 memory unchanged: expect 1277
    repeat (3) @(negedge clk);
    lf = 32'h1ACE5EED;
    for (int i = 0; i < 14; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      runTxn(lf[0], 18'(lf[6:3]), lf[31:16], lf[9:8]);
    end
    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule